// File: doc/BRIEF.md
# Two-Slot Priority Task Dispatcher

This block chooses which of five loadable hardware tasks goes into one of two execution slots of a reconfigurable fabric. Request events arrive as one-cycle pulses on seven queue lines and two push-button trigger lines, and each line is tied to exactly one task. The block keeps a set of pending task requests and the state of every slot. Each slot is in one of three states: SLOT_FREE, SLOT_LOADING or SLOT_RUNNING. Whenever a slot is free and a request is pending, the block picks the most important pending task. It then raises a load command that names the slot and the task.

The command stays up until the loader acknowledges it with `load_done`. At that point the slot counts as running. Scheduling is non-preemptive: a running task leaves its slot only when it reports completion on `task_done`. That completion frees the slot, and the next ready task can then be loaded into it.

The dispatcher controller has two states. In DSP_IDLE it waits for a pending request and a free slot. The transition IDLE→ISSUE ("grant") captures the task and slot, clears the pending bit and moves the slot to SLOT_LOADING. In DSP_ISSUE it holds the command. The transition ISSUE→IDLE ("acknowledge") fires on `load_done` and moves the slot to SLOT_RUNNING. The slot controller has three transitions:
- FREE→LOADING on a grant.
- LOADING→RUNNING on the acknowledge.
- RUNNING→FREE on `task_done`.

Top module: `task_dispatcher`

## Requirements
- R1: A slot in SLOT_RUNNING returns to SLOT_FREE only on its `task_done` bit. A `task_done` pulse for a slot that is free or still loading has no effect.
- R2: There are two slots and each holds at most one task. No load command is raised while no slot is free.
- R3: Task index 0 is the highest priority and index 4 the lowest. A dispatch always takes the lowest-numbered pending task.
- R4: A request for a task that is already pending, or that sits in a slot (loading or running), is absorbed and leaves `pending` unchanged.
- R5: When both slots are free, slot 0 (`load_slot`=0) is filled first. At most one slot is being loaded at any time.
- R6: `load_valid`, `load_slot` and `load_task` stay stable until a `load_done` cycle. The slot then becomes running, and the next command starts no earlier than the following cycle.
- R7: Queue line q (bit q of `queue_evt`) requests task 2 + (q mod 3). Trigger line t (bit t of `trig_evt`) requests task t. The request appears in `pending` (bit n for task n) one cycle after the pulse.
- R8: Completion of a running task frees its slot, and the highest pending task is then loaded into that slot.
- R9: Synchronous active-high `rst` clears `pending`, drops `load_valid` and marks both slots free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| queue_evt | input | 7 | One-cycle request pulses from the queue sources |
| trig_evt | input | 2 | One-cycle request pulses from the trigger sources |
| task_done | input | 2 | Per-slot completion pulse from the running task |
| load_done | input | 1 | Loader acknowledge of the current load command |
| load_valid | output | 1 | Load command active |
| load_slot | output | 1 | Slot named by the load command |
| load_task | output | 3 | Task index named by the load command |
| slot_busy | output | 2 | Per-slot occupied flag (loading or running) |
| pending | output | 5 | Pending request set, bit n for task n |

## Verification
The tests use four kinds of request pattern.

- **Single events while both slots are free.** These separate the slot-0-first rule from the source-to-task mapping.
- **Bursts of events while both slots are occupied.** These show whether duplicates and requests for loaded tasks are absorbed, and that nothing is dispatched while no slot is free.
- **A staggered series of completions.** Several requests are pending, and each completion must release exactly one slot and take the highest pending task, which tells a priority encoder apart from arrival order.
- **Completion pulses on slots that are free or still loading.** These, together with a reset in mid-run, show that only a running slot can be freed.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_LOADING,
        SLOT_RUNNING
    } slot_state_e;

    typedef enum logic {
        DSP_IDLE,
        DSP_ISSUE
    } dsp_state_e;

    // Sources 0..nq-1 are queue lines, nq..nq+ntrig-1 are trigger lines.
    function automatic int src_task(int src, int nq, int ntrig, int ntask);
        if (src >= nq) begin
            return src - nq;
        end
        return ntrig + (src % (ntask - ntrig));
    endfunction

endpackage

// File: rtl/dispatch_event_map.sv
module dispatch_event_map
    import dispatch_pkg::*;
#(
    parameter int NQ    = 7,
    parameter int NTRIG = 2,
    parameter int NTASK = 5
) (
    input  logic [NQ-1:0]    q_evt,
    input  logic [NTRIG-1:0] t_evt,
    output logic [NTASK-1:0] req
);
    localparam int NSRC = NQ + NTRIG;

    function automatic logic [NSRC-1:0] src_mask(int tsk);
        logic [NSRC-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_task(s, NQ, NTRIG, NTASK) == tsk) begin
                m[s] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [NSRC-1:0] all_evt;
    assign all_evt = {t_evt, q_evt};

    for (genvar t = 0; t < NTASK; t++) begin : g_task
        localparam logic [NSRC-1:0] MASK = src_mask(t);
        assign req[t] = |(all_evt & MASK);
    end

endmodule

// File: rtl/dispatch_pick.sv
module dispatch_pick #(
    parameter int N = 5,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    assign found = |vec;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/dispatch_slot.sv
module dispatch_slot
    import dispatch_pkg::*;
#(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant,
    input  logic [TW-1:0] grant_task,
    input  logic          ack,
    input  logic          done,
    output logic          free,
    output logic          loading,
    output logic [TW-1:0] task_id
);
    slot_state_e state_q, state_n;
    logic [TW-1:0] task_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_FREE;
            task_q  <= '0;
        end else begin
            state_q <= state_n;
            if (grant && state_q == SLOT_FREE) begin
                task_q <= grant_task;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SLOT_FREE:    if (grant) state_n = SLOT_LOADING;
            SLOT_LOADING: if (ack)   state_n = SLOT_RUNNING;
            SLOT_RUNNING: if (done)  state_n = SLOT_FREE;
            default:                 state_n = SLOT_FREE;
        endcase
    end

    always_comb begin
        free    = (state_q == SLOT_FREE);
        loading = (state_q == SLOT_LOADING);
        task_id = task_q;
    end

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_RUNNING && !done) |=> (state_q == SLOT_RUNNING)); // R1

    AST_LOADING_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_LOADING && !ack) |=> (state_q == SLOT_LOADING)); // R1

    AST_GRANT_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
        (state_q != SLOT_FREE) |=> (state_q != SLOT_FREE || $past(state_q) == SLOT_RUNNING)); // R2

endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher
    import dispatch_pkg::*;
#(
    parameter int NQ    = 7,
    parameter int NTRIG = 2,
    parameter int NTASK = 5,
    parameter int NSLOT = 2,
    localparam int TW = (NTASK > 1) ? $clog2(NTASK) : 1,
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NQ-1:0]    queue_evt,
    input  logic [NTRIG-1:0] trig_evt,
    input  logic [NSLOT-1:0] task_done,
    input  logic             load_done,
    output logic             load_valid,
    output logic [SW-1:0]    load_slot,
    output logic [TW-1:0]    load_task,
    output logic [NSLOT-1:0] slot_busy,
    output logic [NTASK-1:0] pending
);
    dsp_state_e state_q, state_n;

    logic [NTASK-1:0] req;
    logic [NTASK-1:0] pend_q, pend_n;
    logic [NTASK-1:0] loaded;
    logic [NTASK-1:0] clr_mask;
    logic [NSLOT-1:0] slot_free;
    logic [NSLOT-1:0] slot_loading;
    logic [TW-1:0]    slot_tid [NSLOT];

    logic             task_found;
    logic [TW-1:0]    task_pick;
    logic             slot_found;
    logic [SW-1:0]    slot_pick;
    logic             grant;
    logic             ack;
    logic [SW-1:0]    slot_q;
    logic [TW-1:0]    task_q;
    logic [NTASK-1:0] higher_mask;

    dispatch_event_map #(
        .NQ   (NQ),
        .NTRIG(NTRIG),
        .NTASK(NTASK)
    ) i_map (
        .q_evt(queue_evt),
        .t_evt(trig_evt),
        .req  (req)
    );

    dispatch_pick #(.N(NTASK)) i_task_pick (
        .vec  (pend_q),
        .found(task_found),
        .idx  (task_pick)
    );

    dispatch_pick #(.N(NSLOT)) i_slot_pick (
        .vec  (slot_free),
        .found(slot_found),
        .idx  (slot_pick)
    );

    assign grant = (state_q == DSP_IDLE) && task_found && slot_found;
    assign ack   = (state_q == DSP_ISSUE) && load_done;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        dispatch_slot #(.TW(TW)) i_slot (
            .clk       (clk),
            .rst       (rst),
            .grant     (grant && slot_pick == SW'(s)),
            .grant_task(task_pick),
            .ack       (ack && slot_q == SW'(s)),
            .done      (task_done[s]),
            .free      (slot_free[s]),
            .loading   (slot_loading[s]),
            .task_id   (slot_tid[s])
        );
    end

    // Tasks currently occupying a slot (loading or running)
    always_comb begin
        loaded = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (!slot_free[s]) begin
                loaded = loaded | (NTASK'(1) << slot_tid[s]);
            end
        end
    end

    always_comb begin
        clr_mask = grant ? (NTASK'(1) << task_pick) : '0;
        pend_n   = (pend_q | (req & ~loaded)) & ~clr_mask;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DSP_IDLE;
            pend_q  <= '0;
            slot_q  <= '0;
            task_q  <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
            if (grant) begin
                slot_q <= slot_pick;
                task_q <= task_pick;
            end
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            DSP_IDLE:  if (grant) state_n = DSP_ISSUE;
            DSP_ISSUE: if (ack)   state_n = DSP_IDLE;
            default:              state_n = DSP_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_valid = (state_q == DSP_ISSUE);
        load_slot  = slot_q;
        load_task  = task_q;
        slot_busy  = ~slot_free;
        pending    = pend_q;
    end

    assign higher_mask = (NTASK'(1) << load_task) - NTASK'(1);

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (load_valid && !load_done) |=> (load_valid && $stable(load_slot) && $stable(load_task))); // R6

    AST_NEXT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (load_valid && load_done) |=> !load_valid); // R6

    AST_PEND_NOT_LOADED: assert property (@(posedge clk) disable iff (rst)
        (pending & loaded) == '0); // R4

    AST_TARGET_LOADING: assert property (@(posedge clk) disable iff (rst)
        load_valid |-> slot_loading[load_slot]); // R2

    AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (rst)
        $rose(load_valid) |-> (($past(pending) & higher_mask) == '0)); // R3

    AST_ONE_LOADING: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_loading) <= 1); // R5

endmodule

// File: tb/test_task_dispatcher.sv
module test_task_dispatcher;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] queue_evt = '0;
    logic [1:0] trig_evt = '0;
    logic [1:0] task_done = '0;
    logic       load_done = 1'b0;
    logic       load_valid;
    logic [0:0] load_slot;
    logic [2:0] load_task;
    logic [1:0] slot_busy;
    logic [4:0] pending;

    int checks = 0;
    int errors = 0;
    int ack_delay = 2;
    int exp_slot[$];
    int exp_task[$];
    string exp_req[$];

    always #4 clk = ~clk;

    task_dispatcher i_task_dispatcher (
        .clk(clk), .rst(rst), .queue_evt(queue_evt), .trig_evt(trig_evt),
        .task_done(task_done), .load_done(load_done), .load_valid(load_valid),
        .load_slot(load_slot), .load_task(load_task), .slot_busy(slot_busy),
        .pending(pending)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_load(int s, int t, string req);
        exp_slot.push_back(s);
        exp_task.push_back(t);
        exp_req.push_back(req);
    endtask

    task automatic pulse(logic [6:0] q, logic [1:0] tr, logic [1:0] d);
        @(negedge clk);
        queue_evt = q; trig_evt = tr; task_done = d;
        @(negedge clk);
        queue_evt = '0; trig_evt = '0; task_done = '0;
    endtask

    task automatic drain(string req);
        int n = 0;
        while (exp_task.size() != 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        check(req, "outstanding loads", exp_task.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares each load command with the scoreboard and acknowledges it
    initial begin
        forever begin
            @(negedge clk);
            if (load_valid && !rst) begin
                int es, et;
                string er;
                if (exp_task.size() == 0) begin
                    es = -1; et = -1; er = "R2";
                end else begin
                    es = exp_slot.pop_front();
                    et = exp_task.pop_front();
                    er = exp_req.pop_front();
                end
                check(er, "load_task", int'(load_task), et);
                check(er, "load_slot", int'(load_slot), es);
                for (int k = 0; k < ack_delay; k++) begin
                    @(negedge clk);
                    check("R6", "held load_valid", int'(load_valid), 1);
                    check("R6", "held load_task", int'(load_task), et);
                end
                load_done = 1'b1;
                @(negedge clk);
                load_done = 1'b0;
                check("R6", "load_valid after ack", int'(load_valid), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9", "reset load_valid", int'(load_valid), 0);
        check("R9", "reset slot_busy", int'(slot_busy), 0);
        check("R9", "reset pending", int'(pending), 0);

        // Both free: trigger1 -> task1 and queue0 -> task2
        expect_load(0, 1, "R5");
        expect_load(1, 2, "R7");
        pulse(7'b0000001, 2'b10, 2'b00);
        drain("R5");
        check("R6", "both slots busy", int'(slot_busy), 3);
        check("R7", "pending empty", int'(pending), 0);

        // Both busy: queue6 -> task2 already loaded, absorbed
        pulse(7'b1000000, 2'b00, 2'b00);
        check("R4", "loaded task absorbed", int'(pending), 0);
        pulse(7'b0000100, 2'b00, 2'b00);
        pulse(7'b0000010, 2'b00, 2'b00);
        pulse(7'b0000000, 2'b01, 2'b00);
        pulse(7'b0100000, 2'b00, 2'b00);
        check("R4", "pending tasks 0,3,4", int'(pending), 5'b11001);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2", "no load with no free slot", int'(load_valid), 0);
        end

        // Completions release slots in turn, highest pending first
        expect_load(1, 0, "R3");
        pulse(7'b0, 2'b00, 2'b10);
        drain("R8");
        expect_load(0, 3, "R8");
        pulse(7'b0, 2'b00, 2'b01);
        drain("R8");
        expect_load(1, 4, "R3");
        pulse(7'b0, 2'b00, 2'b10);
        drain("R3");
        check("R8", "pending drained", int'(pending), 0);

        // Free slot 0 with nothing pending; done on a free slot is ignored
        pulse(7'b0, 2'b00, 2'b01);
        check("R8", "slot0 freed", int'(slot_busy), 2'b10);
        pulse(7'b0, 2'b00, 2'b01);
        check("R1", "done on free slot ignored", int'(slot_busy), 2'b10);

        // Done while loading is ignored
        ack_delay = 6;
        expect_load(0, 0, "R7");
        pulse(7'b0, 2'b01, 2'b00);
        wait (load_valid);
        pulse(7'b0, 2'b00, 2'b01);
        drain("R1");
        check("R1", "done during loading ignored", int'(slot_busy), 3);
        ack_delay = 2;

        // Reset mid-run
        pulse(7'b0000010, 2'b00, 2'b00);
        check("R7", "queue1 -> task3 pending", int'(pending), 5'b01000);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R9", "reset clears pending", int'(pending), 0);
        check("R9", "reset frees slots", int'(slot_busy), 0);
        check("R9", "reset drops command", int'(load_valid), 0);

        // Simultaneous burst with both free
        expect_load(0, 0, "R5");
        expect_load(1, 1, "R3");
        pulse(7'b0000110, 2'b11, 2'b00);
        drain("R5");
        check("R4", "tasks 3,4 remain", int'(pending), 5'b11000);
        expect_load(0, 3, "R8");
        pulse(7'b0, 2'b00, 2'b01);
        drain("R8");
        check("R3", "task4 remains", int'(pending), 5'b10000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule